// File: doc/BRIEF.md
# Remainder-Tracking Arithmetic Logic Unit

This block is an 8-bit arithmetic and logic unit that has no carry flag. It keeps a full-width remainder register instead. Every arithmetic operation writes that register. Addition and subtraction place their overflow or borrow bit in it. Multiplication places the high byte of its 16-bit product in it. Division, modulo, increment and decrement also rewrite it. Logic operations and shifts leave it alone. Software can clear the remainder or copy it onto the result bus.

A request is an operation code, two operands and a one-cycle valid strobe. The result, the remainder and three status flags are registered. They change on the clock edge that samples the strobe and then hold until the next strobe. The flags are result-is-zero, remainder-is-zero and operand A greater than operand B as unsigned numbers. A core's sequencer uses them for conditional jumps and returns. Choosing source registers and fetching immediates happen outside the block.

Top module: `rem_alu`

## Requirements
- R1: After reset, `result` and `remainder` are 0x00, `res_zero` and `rem_zero` are 1, and `a_gt_b` is 0.
- R2: When `valid` is high, all outputs take their new values at the next rising clock edge. When `valid` is low, every output holds its value whatever `op`, `opa` and `opb` are.
- R3: Op 0x0 (add) gives the low byte of A+B. The remainder becomes 0x01 when the sum exceeds 255 and 0x00 otherwise. For example, 0x80+0xA0 gives 0x20 with remainder 0x01.
- R4: Op 0x1 (subtract) gives the low byte of A-B. The remainder becomes 0x01 when B > A and 0x00 otherwise.
- R5: Op 0x2 (multiply) gives the low byte of the 16-bit product as the result and puts its high byte in the remainder. For example, 0x45×0xC0 gives 0xC0 with remainder 0x33.
- R6: Op 0x3 (divide) gives the unsigned quotient A/B and op 0x4 (modulo) gives A mod B. Both set the remainder to 0x00.
- R7: Divide or modulo with B = 0x00 gives 0xFF and sets the remainder to 0x00.
- R8: Op 0x5 (increment A) and op 0x6 (decrement A) set the remainder to 0x01 when the value wraps (0xFF→0x00 or 0x00→0xFF) and to 0x00 otherwise.
- R9: These ops leave the remainder unchanged: 0x7 (A shifted left by one, zero in at bit 0), 0x8 (A shifted right by one, zero in at bit 7), 0x9 (NOT A), 0xA (A AND B), 0xB (A OR B) and 0xC (A XOR B).
- R10: Op 0xD (clear) gives A as the result and sets the remainder to 0x00. Op 0xE (read) gives the remainder as it stood before the operation and leaves the remainder unchanged. Op 0xF (pass) gives A and leaves the remainder unchanged.
- R11: `res_zero` is 1 exactly when `result` is 0x00. `rem_zero` is 1 exactly when `remainder` is 0x00. `a_gt_b` is the unsigned comparison A > B of the most recently accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Request strobe, one operation per high cycle |
| op | input | 4 | Operation code (see R3–R10) |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| result | output | 8 | Registered result |
| remainder | output | 8 | Registered remainder register |
| res_zero | output | 1 | Result equals zero |
| rem_zero | output | 1 | Remainder equals zero |
| a_gt_b | output | 1 | Unsigned A > B of the last request |

## Verification
Two things can happen in the same cycle: the result wraps to zero while the remainder becomes nonzero. `res_zero` and `rem_zero` must then disagree in that cycle. The bench forces this with directed operations: add 0x80+0x80, increment 0xFF, and a multiply whose low byte is zero but whose high byte is not. It checks both flags in the one sample taken after the edge. Randomly mixed streams with back-to-back operations show the second case: a read issued right after an arithmetic operation must return the remainder that operation just wrote.

// File: rtl/rem_alu_pkg.sv
package rem_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_MOD  = 4'h4,
        OP_INC  = 4'h5,
        OP_DEC  = 4'h6,
        OP_SHL  = 4'h7,
        OP_SHR  = 4'h8,
        OP_NOT  = 4'h9,
        OP_AND  = 4'hA,
        OP_OR   = 4'hB,
        OP_XOR  = 4'hC,
        OP_RCLR = 4'hD,
        OP_RRD  = 4'hE,
        OP_PASS = 4'hF
    } alu_op_e;

endpackage

// File: rtl/rem_alu_arith.sv
module rem_alu_arith
    import rem_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic [W-1:0]   rem
);
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W:0]     sum;
    logic [W:0]     dif;
    logic [2*W-1:0] prod;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        dif  = {1'b0, a} - {1'b0, b};
        prod = a * b;
        res  = '0;
        rem  = '0;
        case (op)
            OP_ADD: begin
                res = sum[W-1:0];
                rem = sum[W] ? ONE : '0;
            end
            OP_SUB: begin
                res = dif[W-1:0];
                rem = dif[W] ? ONE : '0;
            end
            OP_MUL: begin
                res = prod[W-1:0];
                rem = prod[2*W-1:W];
            end
            OP_INC: begin
                res = a + ONE;
                rem = (a == ONES) ? ONE : '0;
            end
            OP_DEC: begin
                res = a - ONE;
                rem = (a == '0) ? ONE : '0;
            end
            default: begin
                res = '0;
                rem = '0;
            end
        endcase
    end
endmodule

// File: rtl/rem_alu_divider.sv
module rem_alu_divider #(
    parameter int W = 8
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] modulus
);
    logic [W:0]   part;
    logic [W-1:0] quo;

    // restoring division, one compare-subtract stage per quotient bit
    always_comb begin
        part = '0;
        quo  = '0;
        for (int i = W - 1; i >= 0; i--) begin
            part = {part[W-1:0], dividend[i]};
            if (part >= {1'b0, divisor}) begin
                part   = part - {1'b0, divisor};
                quo[i] = 1'b1;
            end
        end
        if (divisor == '0) begin
            quotient = '1;
            modulus  = '1;
        end else begin
            quotient = quo;
            modulus  = part[W-1:0];
        end
    end
endmodule

// File: rtl/rem_alu_logic.sv
module rem_alu_logic
    import rem_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_SHL:  res = {a[W-2:0], 1'b0};
            OP_SHR:  res = {1'b0, a[W-1:1]};
            OP_NOT:  res = ~a;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/rem_alu.sv
module rem_alu
    import rem_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic [W-1:0] remainder,
    output logic         res_zero,
    output logic         rem_zero,
    output logic         a_gt_b
);
    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] rem;
        logic         gt;
    } alu_state_t;

    alu_state_t state_d, state_q;
    alu_op_e    op_e;

    logic [W-1:0] ar_res, ar_rem;
    logic [W-1:0] dv_quo, dv_mod;
    logic [W-1:0] lg_res;

    assign op_e = alu_op_e'(op);

    rem_alu_arith #(.W(W)) u_arith (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .res (ar_res),
        .rem (ar_rem)
    );

    rem_alu_divider #(.W(W)) u_div (
        .dividend (opa),
        .divisor  (opb),
        .quotient (dv_quo),
        .modulus  (dv_mod)
    );

    rem_alu_logic #(.W(W)) u_logic (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .res (lg_res)
    );

    always_comb begin
        state_d = state_q;
        if (valid) begin
            state_d.gt = (opa > opb);
            case (op_e)
                OP_ADD, OP_SUB, OP_MUL, OP_INC, OP_DEC: begin
                    state_d.res = ar_res;
                    state_d.rem = ar_rem;
                end
                OP_DIV: begin
                    state_d.res = dv_quo;
                    state_d.rem = '0;
                end
                OP_MOD: begin
                    state_d.res = dv_mod;
                    state_d.rem = '0;
                end
                OP_RCLR: begin
                    state_d.res = opa;
                    state_d.rem = '0;
                end
                OP_RRD: begin
                    state_d.res = state_q.rem;
                end
                default: begin
                    state_d.res = lg_res;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result    = state_q.res;
    assign remainder = state_q.rem;
    assign a_gt_b    = state_q.gt;
    assign res_zero  = (state_q.res == '0);
    assign rem_zero  = (state_q.rem == '0);
endmodule

// File: rtl/rem_alu_checker.sv
module rem_alu_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid,
    input logic [3:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] result,
    input logic [W-1:0] remainder,
    input logic         res_zero,
    input logic         rem_zero,
    input logic         a_gt_b
);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(result) && $stable(remainder) && $stable(a_gt_b)));

    a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 4'h0) |=>
        ({remainder[0], result} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})) &&
        (remainder[W-1:1] == '0));

    a_r6_div_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (op == 4'h3 || op == 4'h4)) |=> rem_zero);

    a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (op == 4'h3 || op == 4'h4) && opb == '0) |=> (result == '1));

    a_r9_logic_keeps_rem: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op >= 4'h7 && op <= 4'hC) |=> $stable(remainder));

    a_r10_read: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 4'hE) |=> (result == $past(remainder) && $stable(remainder)));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 4'hD) |=> (rem_zero && result == $past(opa)));

    a_r11_gt: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (a_gt_b == ($past(opa) > $past(opb))));
endmodule

bind rem_alu rem_alu_checker #(.W(W)) u_rem_alu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .result    (result),
    .remainder (remainder),
    .res_zero  (res_zero),
    .rem_zero  (rem_zero),
    .a_gt_b    (a_gt_b)
);

// File: tb/rem_alu_bench.sv
module rem_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [3:0] op = 4'h0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [7:0] result, remainder;
    logic       res_zero, rem_zero, a_gt_b;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_res = 8'h00;
    logic [7:0] exp_rem = 8'h00;
    logic       exp_gt  = 1'b0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rem_alu u_rem_alu (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .opa(opa), .opb(opb),
        .result(result), .remainder(remainder), .res_zero(res_zero),
        .rem_zero(rem_zero), .a_gt_b(a_gt_b)
    );

    function automatic string req_of(input logic [3:0] o, input logic [7:0] b);
        case (o)
            4'h0: return "R3";
            4'h1: return "R4";
            4'h2: return "R5";
            4'h3, 4'h4: return (b == 8'h00) ? "R7" : "R6";
            4'h5, 4'h6: return "R8";
            4'hD, 4'hE, 4'hF: return "R10";
            default: return "R9";
        endcase
    endfunction

    // expected {result, remainder} from the requirements
    function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] r);
        logic [15:0] p;
        case (o)
            4'h0: begin p = {8'h00, a} + {8'h00, b}; return {p[7:0], 7'h0, p[8]}; end
            4'h1: return {a - b, 7'h0, (b > a)};
            4'h2: begin p = a * b; return {p[7:0], p[15:8]}; end
            4'h3: return (b == 0) ? 16'hFF00 : {a / b, 8'h00};
            4'h4: return (b == 0) ? 16'hFF00 : {a % b, 8'h00};
            4'h5: return {a + 8'h01, 7'h0, (a == 8'hFF)};
            4'h6: return {a - 8'h01, 7'h0, (a == 8'h00)};
            4'h7: return {a << 1, r};
            4'h8: return {a >> 1, r};
            4'h9: return {~a, r};
            4'hA: return {a & b, r};
            4'hB: return {a | b, r};
            4'hC: return {a ^ b, r};
            4'hD: return {a, 8'h00};
            4'hE: return {r, r};
            default: return {a, r};
        endcase
    endfunction

    task automatic check_outputs(input string tag);
        checks++;
        if (result !== exp_res || remainder !== exp_rem) begin
            errors++;
            $display("FAIL %s op=%h a=%02h b=%02h got res=%02h rem=%02h expected res=%02h rem=%02h",
                     tag, op, opa, opb, result, remainder, exp_res, exp_rem);
        end
        checks++;
        if (res_zero !== (exp_res == 8'h00) || rem_zero !== (exp_rem == 8'h00) || a_gt_b !== exp_gt) begin
            errors++;
            $display("FAIL R11 flags got rz=%b mz=%b gt=%b expected rz=%b mz=%b gt=%b",
                     res_zero, rem_zero, a_gt_b, (exp_res == 8'h00), (exp_rem == 8'h00), exp_gt);
        end
    endtask

    task automatic do_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] e;
        op = o; opa = a; opb = b; valid = 1'b1;
        e = model(o, a, b, exp_rem);
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        exp_res = e[15:8];
        exp_rem = e[7:0];
        exp_gt  = (a > b);
        check_outputs(req_of(o, b));
    endtask

    task automatic idle(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
        op = o; opa = a; opb = b; valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_outputs("R2");
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check_outputs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");

        // directed corner cases
        do_op(4'h0, 8'h80, 8'hA0);          // R3 example
        do_op(4'hE, 8'h00, 8'h00);          // R10 read returns 0x01
        do_op(4'h0, 8'h80, 8'h80);          // R11 result zero, remainder nonzero
        do_op(4'h0, 8'h10, 8'h20);          // R3 no overflow clears
        do_op(4'h1, 8'h05, 8'h09);          // R4 borrow
        do_op(4'h1, 8'h09, 8'h09);          // R4 no borrow
        do_op(4'h2, 8'h45, 8'hC0);          // R5 example
        do_op(4'h2, 8'h80, 8'h02);          // R5 low byte zero, high byte one
        do_op(4'h7, 8'hFF, 8'h00);          // R9 shift keeps rem, zero fill
        do_op(4'h8, 8'hFF, 8'h00);          // R9
        do_op(4'h3, 8'hC8, 8'h07);          // R6
        do_op(4'h2, 8'hFF, 8'hFF);
        do_op(4'h4, 8'hC8, 8'h07);          // R6 clears rem
        do_op(4'h2, 8'hFF, 8'hFF);
        do_op(4'h3, 8'h33, 8'h00);          // R7
        do_op(4'h2, 8'hFF, 8'hFF);
        do_op(4'h4, 8'h33, 8'h00);          // R7
        do_op(4'h5, 8'hFF, 8'h00);          // R8 wrap up
        do_op(4'h5, 8'h7F, 8'h00);          // R8 no wrap
        do_op(4'h6, 8'h00, 8'h00);          // R8 wrap down
        do_op(4'hC, 8'h5A, 8'hFF);          // R9 xor keeps rem
        do_op(4'hD, 8'h42, 8'h00);          // R10 clear
        do_op(4'h2, 8'h10, 8'h10);
        do_op(4'hF, 8'h99, 8'h00);          // R10 pass keeps rem
        idle(4'hD, 8'h00, 8'h00);           // R2 clear ignored when idle
        idle(4'h2, 8'hFF, 8'hFF);           // R2

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] o;
            logic [7:0] a, b;
            o = 4'($urandom());
            a = 8'($urandom());
            b = ($urandom() % 8 == 0) ? 8'h00 : 8'($urandom());
            if ($urandom() % 6 == 0) idle(o, a, b);
            else do_op(o, a, b);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule